// File: doc/BRIEF.md
# Multi-Port Flash Wait-State Controller

This block sits between several requester ports and a single flash read interface. A port raises its request with an address; if the port reports that the word is already held in its read buffer, the block answers that port from the buffer on its own timer, otherwise the port competes for the flash. One flash access is in flight at a time. The access is held for a wait count built from a small control register, then the granted port sees a one-cycle ready pulse carrying the flash word.

The total wait is one optional address wait plus either a programmed 0 to 15 cycle count or an automatic count derived from the flash access time. Each port chooses whether its buffer hits return at once or pay the same total as a flash access. The arbiter runs round-robin or fixed priority, chosen from the control register at run time. Settings are sampled when an access starts, so rewriting the register never alters an access that is already being counted.

Top module: `flash_ws_ctrl`

## Requirements
- R1: After reset the control register holds only the automatic-wait bit set (word 0x004), no ready is asserted and the round-robin pointer selects port 0 first. Layout of the control word: bit 0 fixed-priority select, bit 1 address-wait enable, bit 2 automatic-wait enable, bits 6:3 programmed wait count, bits 7+i buffer wait policy of port i.
- R2: With automatic wait clear, a flash access waits exactly the programmed count (0 to 15); ready rises W+1 cycles after the first clock edge that sees the request with the flash free, W being the total wait.
- R3: Setting the address-wait enable adds exactly one wait cycle to every total.
- R4: With automatic wait set, the count replaces the programmed one and equals the access-time input plus one margin clock plus two clocks.
- R5: A buffer hit on a port whose policy bit is 0 returns with zero wait (ready one cycle after the request is sampled) carrying that port's buffer data.
- R6: A buffer hit on a port whose policy bit is 1 waits the same total as a flash access under the current settings.
- R7: A buffer hit bypasses the arbiter, so it completes while another port's flash access is still being counted.
- R8: In round-robin mode the search starts at the port after the last one whose flash access completed.
- R9: In fixed-priority mode port 0 wins over port 1, which wins over port 2.
- R10: Ready of a port is high for exactly one cycle per access, at most one flash ready is high at a time, and flash reads return the flash word.
- R11: A control register write during an access leaves that access's wait unchanged and takes effect from the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7+NUM_PORTS | Control word to write |
| tacc_clk | input | 4 | Flash access time in clocks, used in automatic mode |
| req | input | NUM_PORTS | Per-port read request, held until ready |
| addr | input | NUM_PORTS*ADDR_W | Per-port read address |
| buf_hit | input | NUM_PORTS | Per-port read-buffer hit, held with the request |
| buf_rdata | input | NUM_PORTS*DATA_W | Per-port read-buffer data |
| fl_rd | output | 1 | Flash read in progress |
| fl_addr | output | ADDR_W | Address of the flash read in progress |
| fl_rdata | input | DATA_W | Flash read data |
| rdy | output | NUM_PORTS | Per-port one-cycle ready |
| rdata | output | NUM_PORTS*DATA_W | Per-port read data, valid with ready |

## Verification
The bench builds the block with its default parameters: three ports, 16-bit addresses and 32-bit data. With three ports a round-robin pointer sitting on the middle port gives a different winner from fixed priority for the same request pair, so both modes are told apart. The 4-bit count and access-time fields reach the full range of totals, from zero up to nineteen with address wait and automatic mode at their limits.

// File: rtl/flash_ws_pkg.sv
// Package flash_ws_pkg
// Shared constants and the wait-total function of the flash wait-state
// controller. Assumes a 4-bit programmed count and a 4-bit access time.
package flash_ws_pkg;
    localparam int WS_W        = 4;             // programmed count / access time width
    localparam int CNT_W       = WS_W + 1;      // holds up to 1 + 15 + 3
    localparam int AUTO_MARGIN = 1;             // margin clock in automatic mode
    localparam int AUTO_FIXED  = 2;             // fixed clocks in automatic mode
    // control word bit positions
    localparam int B_ARB   = 0;
    localparam int B_ADDR  = 1;
    localparam int B_AUTO  = 2;
    localparam int B_FWS   = 3;
    localparam int B_BUFWS = B_FWS + WS_W;

    // Total wait cycles for one access under the given settings.
    function automatic logic [CNT_W-1:0] total_wait(
        input logic            addr_ws,
        input logic            auto_ws,
        input logic [WS_W-1:0] fws,
        input logic [WS_W-1:0] tacc
    );
        logic [CNT_W-1:0] base;
        base = auto_ws ? (CNT_W'(tacc) + CNT_W'(AUTO_MARGIN + AUTO_FIXED))
                       : CNT_W'(fws);
        return base + CNT_W'(addr_ws);
    endfunction
endpackage

// File: rtl/fws_cfg_reg.sv
// Module fws_cfg_reg
// Control register of the wait-state controller. Holds the arbitration
// select, address wait enable, automatic wait enable, programmed count and
// per-port buffer wait policy. Resets with only automatic wait set.
module fws_cfg_reg
    import flash_ws_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    localparam int CFG_W    = B_BUFWS + NUM_PORTS
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CFG_W-1:0]     wdata,
    output logic                 arb_fixed,
    output logic                 addr_ws,
    output logic                 auto_ws,
    output logic [WS_W-1:0]      fws,
    output logic [NUM_PORTS-1:0] buf_ws
);
    // Register update: reset value, then software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_fixed <= 1'b0;
            addr_ws   <= 1'b0;
            auto_ws   <= 1'b1;
            fws       <= '0;
            buf_ws    <= '0;
        end else if (we) begin
            arb_fixed <= wdata[B_ARB];
            addr_ws   <= wdata[B_ADDR];
            auto_ws   <= wdata[B_AUTO];
            fws       <= wdata[B_FWS +: WS_W];
            buf_ws    <= wdata[B_BUFWS +: NUM_PORTS];
        end
    end

    // R1: first cycle after reset shows the reset values
    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> (auto_ws && !addr_ws && !arb_fixed && fws == '0 && buf_ws == '0));
endmodule

// File: rtl/fws_wait_counter.sv
// Module fws_wait_counter
// Down counter for one access. A start while idle loads the wait total;
// done is high in the single cycle the count reaches zero, after which
// the counter goes idle. Assumes start is only raised while idle.
module fws_wait_counter
    import flash_ws_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count state: load on start, count down while busy, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= load;
            end
        end else if (cnt_q == '0) begin
            busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Completion flag for the current access.
    always_comb done = busy && (cnt_q == '0);

    // R2: every counted cycle removes exactly one wait
    assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1));
    // R10: completion lasts a single cycle
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: a started count is not reloaded mid-access
    assert_start_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && cnt_q == $past(load)));
endmodule

// File: rtl/fws_arbiter.sv
// Module fws_arbiter
// Picks one eligible port for the flash. Fixed mode prefers the lowest
// index; round-robin mode searches from the port after the last completed
// one. The pointer moves only when a flash access completes.
module fws_arbiter #(
    parameter int NUM_PORTS = 3,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] elig,
    input  logic                 fixed,
    input  logic                 advance,
    input  logic [IDX_W-1:0]     adv_idx,
    output logic                 gnt_valid,
    output logic [IDX_W-1:0]     gnt_idx
);
    logic [IDX_W-1:0] ptr_q;

    // Winner selection: scan from the farthest candidate so the nearest wins.
    always_comb begin
        int j;
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = NUM_PORTS - 1; k >= 0; k--) begin
            j = fixed ? k : (int'(ptr_q) + k);
            if (j >= NUM_PORTS) j = j - NUM_PORTS;
            if (elig[j]) begin
                gnt_valid = 1'b1;
                gnt_idx   = IDX_W'(j);
            end
        end
    end

    // Round-robin pointer: moves past the port whose access just completed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (advance)
            ptr_q <= (int'(adv_idx) == NUM_PORTS - 1) ? '0 : adv_idx + 1'b1;
    end

    // R8: pointer holds between completions
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));
    // R9: in fixed mode a requesting port 0 always wins
    assert_fixed_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed && elig[0]) |-> (gnt_valid && gnt_idx == '0));
    // a grant is only issued to an eligible port
    assert_grant_elig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> elig[gnt_idx]);
endmodule

// File: rtl/flash_ws_ctrl.sv
// Module flash_ws_ctrl
// Multi-port flash wait-state controller. Flash misses are arbitrated to
// one flash read at a time, counted for the configured wait, and returned
// with a one-cycle ready. Buffer hits run on a per-port timer outside the
// arbiter. Assumes each port holds req, addr and buf_hit until its ready.
module flash_ws_ctrl
    import flash_ws_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    localparam int CFG_W    = B_BUFWS + NUM_PORTS,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [CFG_W-1:0]            cfg_wdata,
    input  logic [WS_W-1:0]             tacc_clk,
    input  logic [NUM_PORTS-1:0]        req,
    input  logic [NUM_PORTS*ADDR_W-1:0] addr,
    input  logic [NUM_PORTS-1:0]        buf_hit,
    input  logic [NUM_PORTS*DATA_W-1:0] buf_rdata,
    output logic                        fl_rd,
    output logic [ADDR_W-1:0]           fl_addr,
    input  logic [DATA_W-1:0]           fl_rdata,
    output logic [NUM_PORTS-1:0]        rdy,
    output logic [NUM_PORTS*DATA_W-1:0] rdata
);
    logic                 arb_fixed, addr_ws, auto_ws;
    logic [WS_W-1:0]      fws;
    logic [NUM_PORTS-1:0] buf_ws;
    logic [CNT_W-1:0]     wait_total;
    logic [NUM_PORTS-1:0] elig, hit_busy, hit_done, flash_rdy;
    logic                 gnt_valid, fl_start, fl_busy, fl_done;
    logic [IDX_W-1:0]     gnt_idx, gidx_q;
    logic [ADDR_W-1:0]    addr_q;

    fws_cfg_reg #(.NUM_PORTS(NUM_PORTS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .arb_fixed(arb_fixed), .addr_ws(addr_ws), .auto_ws(auto_ws),
        .fws(fws), .buf_ws(buf_ws)
    );

    // Wait total under the current settings, sampled by whichever access starts.
    always_comb wait_total = total_wait(addr_ws, auto_ws, fws, tacc_clk);

    // Flash eligibility: a miss request from a port with no buffer timer running.
    always_comb elig = req & ~buf_hit & ~hit_busy;

    fws_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
        .clk(clk), .rst_n(rst_n), .elig(elig), .fixed(arb_fixed),
        .advance(fl_done), .adv_idx(gidx_q),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    // Flash start: a grant while no flash access is in flight.
    always_comb fl_start = gnt_valid && !fl_busy;

    fws_wait_counter u_fl_cnt (
        .clk(clk), .rst_n(rst_n), .start(fl_start), .load(wait_total),
        .busy(fl_busy), .done(fl_done)
    );

    // Access capture: granted port and its address, held for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gidx_q <= '0;
            addr_q <= '0;
        end else if (fl_start) begin
            gidx_q <= gnt_idx;
            addr_q <= addr[int'(gnt_idx)*ADDR_W +: ADDR_W];
        end
    end

    // Flash interface drive.
    always_comb begin
        fl_rd   = fl_busy;
        fl_addr = addr_q;
    end

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        logic             hit_start;
        logic [CNT_W-1:0] hit_load;

        // Buffer start: a hit request on a port not holding the flash.
        always_comb begin
            hit_start = req[i] && buf_hit[i] && !hit_busy[i]
                        && !(fl_busy && int'(gidx_q) == i);
            hit_load  = buf_ws[i] ? wait_total : '0;
        end

        fws_wait_counter u_hit_cnt (
            .clk(clk), .rst_n(rst_n), .start(hit_start), .load(hit_load),
            .busy(hit_busy[i]), .done(hit_done[i])
        );

        // Port return: flash completion for this port or its buffer timer.
        always_comb begin
            flash_rdy[i] = fl_done && (int'(gidx_q) == i);
            rdy[i]       = flash_rdy[i] || hit_done[i];
            rdata[i*DATA_W +: DATA_W] = flash_rdy[i] ? fl_rdata
                                      : hit_done[i]  ? buf_rdata[i*DATA_W +: DATA_W]
                                      : '0;
        end

        // R5: zero-wait hit completes in the cycle after it starts
        assert_hit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_start && !buf_ws[i]) |=> hit_done[i]);
        // R7: flash and buffer never answer the same port together
        assert_src_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(flash_rdy[i] && hit_done[i]));
    end

    // R10: at most one flash ready at a time
    assert_one_flash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flash_rdy));
    // R11: port and address stay fixed while an access is counted
    assert_hold_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_busy && !fl_done) |=> ($stable(gidx_q) && $stable(addr_q)));
    // R1: no ready while held in reset
    assert_no_rdy_reset_R1: assert property (@(posedge clk)
        !rst_n |=> rdy == '0);
endmodule

// File: tb/tb_flash_ws_ctrl.sv
module tb_flash_ws_ctrl;
    localparam int NP = 3, AW = 16, DW = 32, CW = 7 + NP;
    localparam int PERIOD_NS = 20;

    logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic [3:0] tacc_clk = '0;
    logic [NP-1:0] req = '0, buf_hit = '0, rdy;
    logic [NP*AW-1:0] addr;
    logic [NP*DW-1:0] buf_rdata, rdata;
    logic fl_rd;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_rdata;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #(PERIOD_NS/2) clk = ~clk;

    for (genvar p = 0; p < NP; p++) begin : g_src
        assign addr[p*AW +: AW]      = AW'(16'h0100 * (p + 1));
        assign buf_rdata[p*DW +: DW] = 32'hB000_0000 + p;
    end
    assign fl_rdata = {16'hF1A5, fl_addr};

    flash_ws_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tacc_clk(tacc_clk), .req(req), .addr(addr), .buf_hit(buf_hit),
        .buf_rdata(buf_rdata), .fl_rd(fl_rd), .fl_addr(fl_addr),
        .fl_rdata(fl_rdata), .rdy(rdy), .rdata(rdata)
    );

    function automatic logic [CW-1:0] mk(input bit arb, input bit aws, input bit auto,
                                         input int fws, input logic [NP-1:0] bws);
        return {bws, 4'(fws), auto, aws, arb};
    endfunction

    function automatic logic [DW-1:0] exp_flash(input int p);
        return {16'hF1A5, 16'(16'h0100 * (p + 1))};
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [CW-1:0] w);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // One access on port p; returns cycles to ready and the data returned.
    task automatic run_one(input int p, input bit hit, output int lat, output logic [DW-1:0] d);
        @(negedge clk); req[p] = 1'b1; buf_hit[p] = hit; lat = 0; d = '0;
        while (lat < 100) begin
            @(posedge clk); @(negedge clk); lat++;
            if (rdy[p]) break;
        end
        d = rdata[p*DW +: DW];
        req[p] = 1'b0; buf_hit[p] = 1'b0;
        @(negedge clk);
        check(rdy[p] == 1'b0, "R10 ready one cycle", rdy[p], 0);
    endtask

    typedef struct packed {
        logic arb, aws, auto;
        logic [3:0] fws;
        logic [NP-1:0] bws;
        logic [3:0] tacc;
        logic [1:0] port;
        logic hit;
        logic [4:0] expw;
        logic [3:0] req_id;
    } vec_t;

    // total waits derived from the requirements (R2,R3,R4,R5,R6)
    localparam vec_t VECS [12] = '{
        '{1'b0,1'b0,1'b0,4'd0 ,3'b000,4'd0 ,2'd0,1'b0,5'd0 ,4'd2},
        '{1'b0,1'b0,1'b0,4'd3 ,3'b000,4'd0 ,2'd1,1'b0,5'd3 ,4'd2},
        '{1'b0,1'b0,1'b0,4'd15,3'b000,4'd0 ,2'd2,1'b0,5'd15,4'd2},
        '{1'b0,1'b1,1'b0,4'd15,3'b000,4'd0 ,2'd2,1'b0,5'd16,4'd3},
        '{1'b0,1'b1,1'b0,4'd0 ,3'b000,4'd0 ,2'd0,1'b0,5'd1 ,4'd3},
        '{1'b0,1'b0,1'b1,4'd9 ,3'b000,4'd5 ,2'd1,1'b0,5'd8 ,4'd4},
        '{1'b0,1'b1,1'b1,4'd0 ,3'b000,4'd0 ,2'd0,1'b0,5'd4 ,4'd4},
        '{1'b0,1'b1,1'b1,4'd0 ,3'b000,4'd15,2'd2,1'b0,5'd19,4'd4},
        '{1'b0,1'b0,1'b0,4'd5 ,3'b000,4'd0 ,2'd0,1'b1,5'd0 ,4'd5},
        '{1'b0,1'b0,1'b0,4'd5 ,3'b001,4'd0 ,2'd0,1'b1,5'd5 ,4'd6},
        '{1'b0,1'b1,1'b0,4'd5 ,3'b001,4'd0 ,2'd1,1'b1,5'd0 ,4'd5},
        '{1'b0,1'b1,1'b1,4'd3 ,3'b100,4'd2 ,2'd2,1'b1,5'd6 ,4'd6}
    };

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int lat;
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        check(rdy == '0, "R1 no ready in reset", rdy, 0);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset config is automatic mode (tacc 4 -> wait 7)
        tacc_clk = 4'd4;
        run_one(0, 1'b0, lat, d);
        check(lat == 8, "R1 reset automatic wait", lat, 8);
        check(d == exp_flash(0), "R10 flash data", d, exp_flash(0));

        // vector table
        foreach (VECS[i]) begin
            vec_t v;
            v = VECS[i];
            wr_cfg(mk(v.arb, v.aws, v.auto, int'(v.fws), v.bws));
            tacc_clk = v.tacc;
            run_one(int'(v.port), v.hit, lat, d);
            check(lat == int'(v.expw) + 1, $sformatf("R%0d vector %0d latency", v.req_id, i),
                  lat, int'(v.expw) + 1);
            if (v.hit)
                check(d == 32'hB000_0000 + v.port, "R5 buffer data", d, 32'hB000_0000 + v.port);
            else
                check(d == exp_flash(int'(v.port)), "R10 flash data", d, exp_flash(int'(v.port)));
        end

        // R8: round-robin, pointer past port 0 -> port 2 beats port 0
        wr_cfg(mk(0, 0, 0, 0, '0));
        run_one(0, 1'b0, lat, d);
        @(negedge clk); req[0] = 1'b1; req[2] = 1'b1;
        @(posedge clk); @(negedge clk);
        check(rdy == 3'b100, "R8 round-robin winner", rdy, 3'b100);
        req[2] = 1'b0;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        check(rdy == 3'b001, "R8 round-robin second", rdy, 3'b001);
        req[0] = 1'b0;
        @(negedge clk);

        // R9: fixed priority, same request pair -> port 0 first
        wr_cfg(mk(1, 0, 0, 0, '0));
        run_one(1, 1'b0, lat, d);
        @(negedge clk); req[0] = 1'b1; req[2] = 1'b1;
        @(posedge clk); @(negedge clk);
        check(rdy == 3'b001, "R9 fixed priority winner", rdy, 3'b001);
        req[0] = 1'b0;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        check(rdy == 3'b100, "R9 fixed priority second", rdy, 3'b100);
        req[2] = 1'b0;
        @(negedge clk);

        // R7: buffer hit completes during a 10-wait flash access
        wr_cfg(mk(0, 0, 0, 10, '0));
        @(negedge clk); req[0] = 1'b1; req[1] = 1'b1; buf_hit[1] = 1'b1;
        @(posedge clk); @(negedge clk);
        check(rdy == 3'b010, "R7 hit not blocked", rdy, 3'b010);
        check(rdata[DW +: DW] == 32'hB000_0001, "R5 hit data", rdata[DW +: DW], 32'hB000_0001);
        req[1] = 1'b0; buf_hit[1] = 1'b0; lat = 1;
        while (lat < 100) begin
            @(posedge clk); @(negedge clk); lat++;
            if (rdy[0]) break;
        end
        check(lat == 11, "R7 flash latency alongside hit", lat, 11);
        req[0] = 1'b0;
        @(negedge clk);

        // R11: rewrite config mid-access
        wr_cfg(mk(0, 0, 0, 8, '0));
        @(negedge clk); req[0] = 1'b1; lat = 0;
        while (lat < 100) begin
            @(posedge clk); @(negedge clk); lat++;
            cfg_we = (lat == 3);
            cfg_wdata = mk(0, 0, 0, 0, '0);
            if (rdy[0]) break;
        end
        cfg_we = 1'b0; req[0] = 1'b0;
        check(lat == 9, "R11 access keeps old wait", lat, 9);
        @(negedge clk);
        run_one(0, 1'b0, lat, d);
        check(lat == 1, "R11 new wait next access", lat, 1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule